// File: doc/BRIEF.md
# Host Slave Port with Run-Error Detection

This block sits between an external host, which moves single words or bursts through a simple strobe interface, and an internal data path that produces or consumes one word at a time through a valid/ready handshake. A four-entry FIFO of 8-bit words separates the two sides. A direction input selects the transfer direction. In write direction the host fills the FIFO and the internal side drains it. In read direction the internal side fills the FIFO and the host drains it. The internal handshake is the same whether a register path serves it word by word or a streaming engine does.

A host write that finds no room, or a host read that finds no word, is a run error. Both kinds of error set one sticky status flag. A write that fails is dropped and leaves the FIFO as it was. A read that fails presents the previously returned word again. A second sticky flag, busy, records that a burst found the FIFO in an unfavourable state. Each flag has an enable bit in a control register. A global enable input gates both. The registered interrupt output is a level.

Top module: `hsp_port`

## Requirements
- R1: After reset the FIFO is empty (outValid low, inReady equal to dirRead), statusQ, ctrlQ, hostRdata and irq are all zero.
- R2: With dirRead low, each hostWr pulse stores hostWdata into the FIFO. The internal side sees words in arrival order on outData while outValid is high, and each cycle with outValid and outReady both high removes one word.
- R3: With dirRead low, a hostWr in a cycle that starts with four words stored discards hostWdata, leaves the FIFO contents and order unchanged, and sets statusQ bit 5 at the next clock edge.
- R4: With dirRead high, inReady is high while fewer than four words are stored, and inValid with inReady stores inData. A hostRd with a word available removes the oldest word, and that word appears on hostRdata after the clock edge and stays there until the next successful read.
- R5: With dirRead high, a hostRd in a cycle that starts with the FIFO empty leaves hostRdata at its previous value and sets statusQ bit 5 at the next clock edge.
- R6: statusQ bit 6 (busy) is set at a clock edge where hostBurst is high and the FIFO is non-empty in write direction, or empty in read direction.
- R7: statusQ bits 6 and 5 are sticky. Writing the status register (regWe with regSel high) clears each flag whose regWdata bit is 1 and leaves flags whose bit is 0. A flag event in the same cycle as its clear leaves the flag set. All other statusQ bits read 0.
- R8: Writing the control register (regWe with regSel low) stores regWdata, which reads back on ctrlQ. Bit 6 enables the busy source and bit 5 enables the run-error source. irq goes high one clock after globalIntEn is high and some flag is set together with its enable, and goes low one clock after that condition ends.
- R9: hostWr in read direction and hostRd in write direction have no effect on the FIFO, hostRdata or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirRead | input | 1 | 0: host writes, internal drains; 1: internal fills, host reads |
| hostBurst | input | 1 | High while a host burst is in progress |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 8 | Host write data |
| hostRd | input | 1 | Host read strobe |
| hostRdata | output | 8 | Last word returned to the host |
| inValid | input | 1 | Internal producer has a word |
| inData | input | 8 | Internal producer data |
| inReady | output | 1 | FIFO accepts an internal word |
| outValid | output | 1 | FIFO offers a word to the internal consumer |
| outData | output | 8 | Oldest FIFO word |
| outReady | input | 1 | Internal consumer takes the word |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | 0: control register, 1: status register (write 1 to clear) |
| regWdata | input | 8 | Register write data |
| ctrlQ | output | 8 | Control register contents |
| statusQ | output | 8 | Status flags: bit 6 busy, bit 5 run error |
| globalIntEn | input | 1 | Global interrupt enable |
| irq | output | 1 | Registered level interrupt request |

## Verification
The hardest case to reach is a flag clear that lands in the same cycle as a new event for that flag. The bench first leaves the run-error flag set from earlier errors. It then turns to read direction with the FIFO empty and issues a failing host read on the same clock as the status write that clears the flag, so the flag must survive. Overrun is reached with a fifth write that arrives after four writes and no drain. The bench then drains the FIFO completely, which shows that the dropped word never entered it. Clear and refill steps keep the busy and run-error flags apart, and each flag is checked only after the FIFO has been brought to the required fill level under the right direction.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int BUSY_BIT = 6;
  localparam int RUN_BIT  = 5;

  typedef struct packed {
    logic push;      // store one word
    logic pushHost;  // word comes from host (else internal producer)
    logic pop;       // remove oldest word
    logic loadLast;  // oldest word goes to host read register
  } fifoStrobes_t;
endpackage

// File: rtl/hsp_datapath.sv
module hsp_datapath
  import hsp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      stb,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic [DATA_W-1:0] hostRdata,
  output logic              full,
  output logic              empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;
  logic [DATA_W-1:0] pushData;

  assign pushData = stb.pushHost ? hostWdata : inData;
  assign outData  = mem[rdPtr];
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      hostRdata <= '0;
    end else begin
      if (stb.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (stb.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({stb.push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (stb.loadLast) hostRdata <= outData;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !stb.push);
  a_r4_read_loads_head: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadLast |=> hostRdata == $past(outData));
endmodule

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
  import hsp_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirRead,
  input  logic             hostBurst,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic             inValid,
  input  logic             outReady,
  input  logic             full,
  input  logic             empty,
  input  logic             regWe,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWdata,
  input  logic             globalIntEn,
  output fifoStrobes_t     stb,
  output logic             inReady,
  output logic             outValid,
  output logic [REG_W-1:0] ctrlQ,
  output logic [REG_W-1:0] statusQ,
  output logic             irq
);
  localparam int NSRC = 2;
  localparam int SRC_POS [NSRC] = '{BUSY_BIT, RUN_BIT};

  logic pushHost, pushInt, popHost, popInt;
  logic [NSRC-1:0] srcEv, srcFlag, srcEn, srcClr;

  assign pushHost = hostWr && !dirRead && !full;
  assign pushInt  = inValid && dirRead && !full;
  assign popHost  = hostRd && dirRead && !empty;
  assign popInt   = outReady && !dirRead && !empty;

  assign stb.push     = pushHost || pushInt;
  assign stb.pushHost = pushHost;
  assign stb.pop      = popHost || popInt;
  assign stb.loadLast = popHost;

  assign outValid = !dirRead && !empty;
  assign inReady  = dirRead && !full;

  // source 0: busy, source 1: run error
  assign srcEv[0] = hostBurst && (dirRead ? empty : !empty);
  assign srcEv[1] = (hostWr && !dirRead && full) || (hostRd && dirRead && empty);

  always_ff @(posedge clk) begin
    if (!rstN)                ctrlQ <= '0;
    else if (regWe && !regSel) ctrlQ <= regWdata;
  end

  for (genvar s = 0; s < NSRC; s++) begin : gSrc
    assign srcEn[s]  = ctrlQ[SRC_POS[s]];
    assign srcClr[s] = regWe && regSel && regWdata[SRC_POS[s]];
    always_ff @(posedge clk) begin
      if (!rstN) srcFlag[s] <= 1'b0;
      else       srcFlag[s] <= srcEv[s] || (srcFlag[s] && !srcClr[s]);
    end
  end

  always_comb begin
    statusQ = '0;
    for (int s = 0; s < NSRC; s++) statusQ[SRC_POS[s]] = srcFlag[s];
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= globalIntEn && |(srcFlag & srcEn);
  end

  a_r3_overrun_sets_run: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !dirRead && full) |=> statusQ[RUN_BIT]);
  a_r5_underrun_sets_run: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && dirRead && empty) |=> statusQ[RUN_BIT]);
  a_r7_clear_wins_alone: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regSel && regWdata[RUN_BIT] && !srcEv[1]) |=> !statusQ[RUN_BIT]);
  a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    srcEv[1] |=> statusQ[RUN_BIT]);
  a_r8_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    !globalIntEn |=> !irq);
  a_r8_busy_raises_irq: assert property (@(posedge clk) disable iff (!rstN)
    (globalIntEn && statusQ[BUSY_BIT] && ctrlQ[BUSY_BIT]) |=> irq);
endmodule

// File: rtl/hsp_port.sv
module hsp_port
  import hsp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirRead,
  input  logic              hostBurst,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              hostRd,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady,
  input  logic              regWe,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  ctrlQ,
  output logic [REG_W-1:0]  statusQ,
  input  logic              globalIntEn,
  output logic              irq
);
  fifoStrobes_t stb;
  logic dpFull, dpEmpty;

  hsp_ctrl #(.REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .dirRead(dirRead), .hostBurst(hostBurst),
    .hostWr(hostWr), .hostRd(hostRd), .inValid(inValid), .outReady(outReady),
    .full(dpFull), .empty(dpEmpty), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .globalIntEn(globalIntEn), .stb(stb),
    .inReady(inReady), .outValid(outValid), .ctrlQ(ctrlQ),
    .statusQ(statusQ), .irq(irq)
  );

  hsp_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWdata(hostWdata),
    .inData(inData), .outData(outData), .hostRdata(hostRdata),
    .full(dpFull), .empty(dpEmpty)
  );

  a_r5_rdata_holds: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && dirRead && dpEmpty) |=> $stable(hostRdata));
  a_r9_wrong_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    (dirRead && hostWr && !inValid && !hostRd) |=> $stable(hostRdata));
endmodule

// File: tb/tb_hsp_port.sv
module tb_hsp_port;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirRead = 0, hostBurst = 0, hostWr = 0, hostRd = 0;
  logic [7:0] hostWdata = '0, inData = '0, regWdata = '0;
  logic inValid = 0, outReady = 0, regWe = 0, regSel = 0, globalIntEn = 0;
  logic [7:0] hostRdata, outData, ctrlQ, statusQ;
  logic inReady, outValid, irq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  hsp_port dut (
    .clk(clk), .rstN(rstN), .dirRead(dirRead), .hostBurst(hostBurst),
    .hostWr(hostWr), .hostWdata(hostWdata), .hostRd(hostRd),
    .hostRdata(hostRdata), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData),
    .outReady(outReady), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .ctrlQ(ctrlQ), .statusQ(statusQ),
    .globalIntEn(globalIntEn), .irq(irq)
  );

  typedef struct packed {
    logic dir, wr, rd; logic [7:0] wd;
    logic inV; logic [7:0] inD; logic outR;
    logic eOV; logic [7:0] eOD; logic [7:0] eRd; logic eRun;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VEC [NVEC] = '{
    '{0,1,0,8'h11,0,8'h00,0, 1,8'h11,8'h00,0},
    '{0,1,0,8'h22,0,8'h00,0, 1,8'h11,8'h00,0},
    '{0,1,0,8'h33,0,8'h00,0, 1,8'h11,8'h00,0},
    '{0,1,0,8'h44,0,8'h00,0, 1,8'h11,8'h00,0},
    '{0,1,0,8'h55,0,8'h00,0, 1,8'h11,8'h00,1},
    '{0,0,0,8'h00,0,8'h00,1, 1,8'h22,8'h00,1},
    '{0,1,0,8'h66,0,8'h00,1, 1,8'h33,8'h00,1},
    '{0,0,0,8'h00,0,8'h00,1, 1,8'h44,8'h00,1},
    '{0,0,0,8'h00,0,8'h00,1, 1,8'h66,8'h00,1},
    '{0,0,0,8'h00,0,8'h00,1, 0,8'h00,8'h00,1},
    '{1,0,1,8'h00,0,8'h00,0, 0,8'h00,8'h00,1},
    '{1,0,0,8'h00,1,8'hA1,0, 0,8'h00,8'h00,1},
    '{1,0,1,8'h00,1,8'hB2,0, 0,8'h00,8'hA1,1},
    '{1,0,1,8'h00,0,8'h00,0, 0,8'h00,8'hB2,1},
    '{1,0,1,8'h00,0,8'h00,0, 0,8'h00,8'hB2,1},
    '{1,1,1,8'h77,0,8'h00,0, 0,8'h00,8'hB2,1},
    '{0,0,0,8'h00,0,8'h00,1, 0,8'h00,8'hB2,1}
  };

  function automatic string vecTag(int i);
    if (i < 4)  return "R2";
    if (i < 9)  return "R3";
    if (i == 9) return "R2";
    if (i < 14) return "R4";
    if (i == 14) return "R5";
    return "R9";
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    hostWr = 0; hostRd = 0; hostBurst = 0; inValid = 0; outReady = 0;
    regWe = 0; regSel = 0; regWdata = '0;
  endtask

  task automatic regWrite(logic sel, logic [7:0] d);
    regWe = 1; regSel = sel; regWdata = d;
    step();
    regWe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 outValid", outValid, 0);
    chk("R1 inReady", inReady, 0);
    chk("R1 statusQ", statusQ, 0);
    chk("R1 ctrlQ", ctrlQ, 0);
    chk("R1 hostRdata", hostRdata, 0);
    chk("R1 irq", irq, 0);
    dirRead = 1; #1;
    chk("R1 inReady read dir", inReady, 1);
    dirRead = 0;

    for (int i = 0; i < NVEC; i++) begin
      dirRead = VEC[i].dir; hostWr = VEC[i].wr; hostRd = VEC[i].rd;
      hostWdata = VEC[i].wd; inValid = VEC[i].inV; inData = VEC[i].inD;
      outReady = VEC[i].outR;
      step();
      nChecks++;
      if (outValid !== VEC[i].eOV || (VEC[i].eOV && outData !== VEC[i].eOD) ||
          hostRdata !== VEC[i].eRd || statusQ[5] !== VEC[i].eRun) begin
        nFails++;
        $display("FAIL %s vector %0d: actual ov=%0b od=%0h rd=%0h run=%0b expected ov=%0b od=%0h rd=%0h run=%0b",
                 vecTag(i), i, outValid, outData, hostRdata, statusQ[5],
                 VEC[i].eOV, VEC[i].eOD, VEC[i].eRd, VEC[i].eRun);
      end
    end
    idle();

    // R7 zero bits and busy bit leave run flag
    regWrite(1, 8'h00);
    chk("R7 zero write keeps flag", statusQ, 8'h20);
    regWrite(1, 8'h40);
    chk("R7 other bit keeps flag", statusQ, 8'h20);
    // R7 event in same cycle as clear wins
    dirRead = 1; hostRd = 1;
    regWrite(1, 8'h20);
    hostRd = 0;
    chk("R7 event beats clear", statusQ, 8'h20);
    chk("R5 rdata held", hostRdata, 8'hB2);
    regWrite(1, 8'h20);
    chk("R7 clear", statusQ, 8'h00);
    // R5 underrun alone sets flag
    hostRd = 1; step(); hostRd = 0;
    chk("R5 underrun flag", statusQ, 8'h20);
    chk("R5 rdata repeat", hostRdata, 8'hB2);

    // R8 control and interrupt
    regWrite(0, 8'hFF);
    chk("R8 ctrl readback", ctrlQ, 8'hFF);
    regWrite(0, 8'h20);
    chk("R8 irq gated off", irq, 0);
    globalIntEn = 1; step();
    chk("R8 irq rises", irq, 1);
    regWrite(1, 8'h20);
    chk("R8 irq lags clear", irq, 1);
    step();
    chk("R8 irq falls", irq, 0);

    // R6 busy in write direction
    regWrite(0, 8'h40);
    dirRead = 0; hostBurst = 1; hostWr = 1; hostWdata = 8'h5A;
    step(); hostWr = 0;
    chk("R6 busy not on empty write", statusQ, 8'h00);
    step();
    chk("R6 busy on nonempty write", statusQ, 8'h40);
    chk("R8 irq one after flag", irq, 0);
    hostBurst = 0; step();
    chk("R8 busy irq", irq, 1);
    regWrite(1, 8'h40);
    chk("R6 busy cleared", statusQ, 8'h00);
    dirRead = 1; hostBurst = 1; step();
    chk("R6 busy not on nonempty read", statusQ, 8'h00);
    hostBurst = 0; hostRd = 1; step(); hostRd = 0;
    chk("R4 rdata", hostRdata, 8'h5A);
    hostBurst = 1; step(); hostBurst = 0;
    chk("R6 busy on empty read", statusQ, 8'h40);

    // R4 fill to full, inReady drops
    for (int k = 1; k <= 4; k++) begin
      inValid = 1; inData = 8'(k); step();
    end
    chk("R4 inReady full", inReady, 0);
    inData = 8'h99; step(); inValid = 0;
    for (int k = 1; k <= 4; k++) begin
      hostRd = 1; step();
      chk("R4 read order", hostRdata, 32'(k));
    end
    hostRd = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule